// File: doc/BRIEF.md
# DMA Channel Interrupt Register Set

This block holds the interrupt state of a single DMA channel. The channel engine feeds it two kinds of input. The first is a live status word that the block shows unchanged. The second is a pair of one-cycle event pulses, one for a finished transfer and one for an accepted abort. The block records each event in a sticky request register. Software clears that register by writing ones to it. An enable mask selects which request bits may raise the interrupt. A read-only detect view shows the request bits that the mask lets through.

The interrupt output is a level signal formed from the detect view. Many channels can wire-OR their outputs onto one shared line. The handler for that line reads each channel's detect view to find the channel that raised it. A channel whose detect view is zero never drives the line. During an abort, software polls the abort bit of the request register and does not wait for the interrupt.

Top module: `chan_irq_regs`

## Requirements
- R1: After reset the request and enable registers hold zero, the detect view reads zero and `irqOut` is low.
- R2: Offset 0x10 reads the live `hwStatus` input in the same cycle, masked to the two implemented bits (bit 1 and bit 13). All other bits read zero. A write to 0x10 changes no register.
- R3: A pulse on `evtDone` sets bit 1 of the request register (offset 0x14) at the next clock edge. The bit stays set until software clears it.
- R4: A pulse on `evtAbort` sets both bit 13 and bit 1 of the request register at the next clock edge.
- R5: A write to 0x14 clears each request bit written as 1 and leaves each bit written as 0 unchanged.
- R6: If an event and a write-one-to-clear reach the same request bit in the same cycle, the bit is set after that edge.
- R7: The enable register at 0x18 stores only bits 1 and 13 of the written word. All other bits read zero.
- R8: Offset 0x1C reads the request register ANDed with the enable register. A write to 0x1C changes no register.
- R9: `irqOut` is high exactly when at least one detect bit is set. It stays low when a request bit is set but that bit is not enabled.
- R10: Any offset other than 0x10, 0x14, 0x18 and 0x1C reads zero. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hwStatus | input | 32 | Live status word from the channel engine |
| evtDone | input | 1 | One-cycle pulse when a transfer finishes |
| evtAbort | input | 1 | One-cycle pulse when an abort is accepted |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 8 | Byte offset within the channel window |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| irqOut | output | 1 | Level interrupt, wire-OR capable |

## Verification
The hardest case to reach is a collision: an event pulse and a write-one-to-clear land on the same request bit in the same cycle. Only that case decides whether set wins over clear. The bench reaches it by driving `evtDone` and a clear of bit 1 on the same falling edge, so both arrive at one rising edge. The second hard case is a request bit that is set but masked. Here the bench checks that the detect view and `irqOut` stay quiet, then enables only the abort bit and checks that the line rises only through that bit.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;

  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_STATUS = 3'd1,
    SEL_REQ    = 3'd2,
    SEL_EN     = 3'd3,
    SEL_DET    = 3'd4
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    clrReq;   // write-one-to-clear on the request register
    logic    wrEnable; // load enable register
    logic    setDone;  // done event this cycle
    logic    setAbort; // abort event this cycle
    regSel_e rdSel;    // register selected for read
  } irqStrobe_t;

endpackage

// File: rtl/chan_irq_ctrl.sv
module chan_irq_ctrl
  import chan_irq_pkg::*;
#(
  parameter int OFF_W      = 8,
  parameter int OFF_STATUS = 'h10,
  parameter int OFF_REQ    = 'h14,
  parameter int OFF_EN     = 'h18,
  parameter int OFF_DET    = 'h1C
) (
  input  logic             regWrEn,
  input  logic [OFF_W-1:0] regAddr,
  input  logic             evtDone,
  input  logic             evtAbort,
  output irqStrobe_t       strb
);

  localparam logic [OFF_W-1:0] ADDR_STATUS = OFF_W'(OFF_STATUS);
  localparam logic [OFF_W-1:0] ADDR_REQ    = OFF_W'(OFF_REQ);
  localparam logic [OFF_W-1:0] ADDR_EN     = OFF_W'(OFF_EN);
  localparam logic [OFF_W-1:0] ADDR_DET    = OFF_W'(OFF_DET);

  regSel_e sel;

  always_comb begin
    unique case (regAddr)
      ADDR_STATUS: sel = SEL_STATUS;
      ADDR_REQ:    sel = SEL_REQ;
      ADDR_EN:     sel = SEL_EN;
      ADDR_DET:    sel = SEL_DET;
      default:     sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strb.rdSel    = sel;
    // Only the request and enable registers accept writes
    strb.clrReq   = regWrEn && (sel == SEL_REQ);
    strb.wrEnable = regWrEn && (sel == SEL_EN);
    strb.setDone  = evtDone;
    strb.setAbort = evtAbort;
  end

endmodule

// File: rtl/chan_irq_datapath.sv
module chan_irq_datapath
  import chan_irq_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int DONE_BIT  = 1,
  parameter int ABORT_BIT = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  irqStrobe_t       strb,
  input  logic [REG_W-1:0] wrData,
  input  logic [REG_W-1:0] hwStatus,
  output logic [REG_W-1:0] rdData,
  output logic             irqOut
);

  localparam logic [REG_W-1:0] ONE        = {{(REG_W-1){1'b0}}, 1'b1};
  localparam logic [REG_W-1:0] DONE_MASK  = ONE << DONE_BIT;
  localparam logic [REG_W-1:0] ABORT_MASK = ONE << ABORT_BIT;
  localparam logic [REG_W-1:0] IMPL_MASK  = DONE_MASK | ABORT_MASK;

  logic [REG_W-1:0] reqQ, enQ, setVec, clrVec, detVal;

  // An abort also reports done
  always_comb begin
    setVec = '0;
    if (strb.setDone || strb.setAbort) setVec = setVec | DONE_MASK;
    if (strb.setAbort)                 setVec = setVec | ABORT_MASK;
  end

  assign clrVec = strb.clrReq ? (wrData & IMPL_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqQ <= '0;
      enQ  <= '0;
    end else begin
      reqQ <= (reqQ & ~clrVec) | setVec;  // set has priority
      if (strb.wrEnable) enQ <= wrData & IMPL_MASK;
    end
  end

  assign detVal = reqQ & enQ;
  assign irqOut = |detVal;

  always_comb begin
    unique case (strb.rdSel)
      SEL_STATUS: rdData = hwStatus & IMPL_MASK;
      SEL_REQ:    rdData = reqQ;
      SEL_EN:     rdData = enQ;
      SEL_DET:    rdData = detVal;
      default:    rdData = '0;
    endcase
  end

  // R3 / R6: a done event always leaves the done bit set
  p_done_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.setDone |=> reqQ[DONE_BIT]);

  // R4: an abort sets both bits
  p_abort_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.setAbort |=> (reqQ[ABORT_BIT] && reqQ[DONE_BIT]));

  // R5: with no clear and no event the request register holds
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.clrReq && !strb.setDone && !strb.setAbort) |=> $stable(reqQ));

  // R5: a clear of the abort bit with no abort event empties it
  p_abort_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.clrReq && wrData[ABORT_BIT] && !strb.setAbort) |=> !reqQ[ABORT_BIT]);

  // R7: unimplemented bits never hold state
  p_unused_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((enQ & ~IMPL_MASK) == '0) && ((reqQ & ~IMPL_MASK) == '0));

  // R9: no interrupt while nothing is enabled
  p_quiet_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enQ == '0) |-> !irqOut);

  // R8 / R10: the enable register changes only through its own write strobe
  p_en_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrEnable |=> $stable(enQ));

endmodule

// File: rtl/chan_irq_regs.sv
module chan_irq_regs
  import chan_irq_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int OFF_W     = 8,
  parameter int DONE_BIT  = 1,
  parameter int ABORT_BIT = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] hwStatus,
  input  logic             evtDone,
  input  logic             evtAbort,
  input  logic             regWrEn,
  input  logic [OFF_W-1:0] regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             irqOut
);

  irqStrobe_t strb;

  chan_irq_ctrl #(
    .OFF_W (OFF_W)
  ) u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .evtDone  (evtDone),
    .evtAbort (evtAbort),
    .strb     (strb)
  );

  chan_irq_datapath #(
    .REG_W     (REG_W),
    .DONE_BIT  (DONE_BIT),
    .ABORT_BIT (ABORT_BIT)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .wrData   (regWrData),
    .hwStatus (hwStatus),
    .rdData   (regRdData),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/chan_irq_regs_test.sv
module chan_irq_regs_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam logic [7:0] A_STAT = 8'h10, A_REQ = 8'h14, A_EN = 8'h18, A_DET = 8'h1C;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] hwStatus = '0;
  logic        evtDone = 0, evtAbort = 0, regWrEn = 0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  chan_irq_regs uut (
    .clk(clk), .rst_n(rst_n), .hwStatus(hwStatus), .evtDone(evtDone),
    .evtAbort(evtAbort), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic pulse(bit done, bit abrt);
    @(negedge clk);
    evtDone = done; evtAbort = abrt;
    @(negedge clk);
    evtDone = 0; evtAbort = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_REQ, v);  check("R1 request", v, 32'h0);
    rd(A_EN, v);   check("R1 enable", v, 32'h0);
    rd(A_DET, v);  check("R1 detect", v, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_status;
    logic [31:0] v;
    hwStatus = 32'hFFFF_FFFF;
    rd(A_STAT, v); check("R2 status mask", v, 32'h0000_2002);
    hwStatus = 32'h0000_0002;
    rd(A_STAT, v); check("R2 status live", v, 32'h0000_0002);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_REQ, v);  check("R2 write ignored req", v, 32'h0);
    rd(A_EN, v);   check("R2 write ignored en", v, 32'h0);
    hwStatus = '0;
  endtask

  task automatic t_done;
    logic [31:0] v;
    pulse(1, 0);
    rd(A_REQ, v); check("R3 done set", v, 32'h0000_0002);
    repeat (3) @(negedge clk);
    rd(A_REQ, v); check("R3 done sticky", v, 32'h0000_0002);
    check("R9 masked irq low", {31'b0, irqOut}, 32'h0);
    rd(A_DET, v); check("R8 detect masked", v, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, v);  check("R7 enable bits", v, 32'h0000_2002);
    rd(A_DET, v); check("R8 detect and", v, 32'h0000_0002);
    check("R9 irq high", {31'b0, irqOut}, 32'h1);
    wr(A_DET, 32'h0);
    rd(A_DET, v); check("R8 detect write ignored", v, 32'h0000_0002);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(A_REQ, 32'h0);
    rd(A_REQ, v); check("R5 zero keeps", v, 32'h0000_0002);
    wr(A_REQ, 32'h0000_0002);
    rd(A_REQ, v); check("R5 one clears", v, 32'h0);
    check("R9 irq low after clear", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_abort;
    logic [31:0] v;
    pulse(0, 1);
    rd(A_REQ, v); check("R4 abort sets both", v, 32'h0000_2002);
    wr(A_REQ, 32'h0000_2000);
    rd(A_REQ, v); check("R5 partial clear", v, 32'h0000_0002);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    @(negedge clk);
    regAddr = A_REQ; regWrData = 32'h0000_2002; regWrEn = 1; evtDone = 1;
    @(negedge clk);
    regWrEn = 0; evtDone = 0;
    rd(A_REQ, v); check("R6 set wins", v, 32'h0000_0002);
    wr(A_REQ, 32'h0000_2002);
    rd(A_REQ, v); check("R6 later clear", v, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0);
    rd(8'h20, v); check("R10 unmapped read", v, 32'h0);
    rd(A_EN, v);  check("R10 enable untouched", v, 32'h0000_2002);
    rd(A_REQ, v); check("R10 request untouched", v, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(A_EN, 32'h0000_2000);
    pulse(1, 0);
    rd(A_DET, v); check("R9 done masked detect", v, 32'h0);
    check("R9 done masked irq", {31'b0, irqOut}, 32'h0);
    pulse(0, 1);
    rd(A_DET, v); check("R8 abort detect", v, 32'h0000_2000);
    check("R9 abort irq", {31'b0, irqOut}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_status();
    t_done();
    t_enable();
    t_w1c();
    t_abort();
    t_collide();
    t_unmapped();
    t_mask();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule